// File: doc/BRIEF.md
# DSP Address Generator with Circular and Bit-Reversed Stepping

This block produces one data-memory address per clock for a signal-processing inner loop. It holds an address register made of a base, a power-of-two region size and a running offset. Each request selects how the address is formed: an absolute value taken from the request, the register itself, the register plus a displacement, a post-increment, or a pre-decrement. A second select picks how the offset is turned into an index:
- linear, where the offset is used as it is;
- circular, where the offset wraps inside the region;
- bit-reversed, where the low bits of the offset are mirrored to give FFT reordering.

A sample-history buffer uses circular pre-decrement by one. This reads the newest entry and then the older ones, at index (start - j) mod size. Circular post-increment advances a write pointer as (start + 1) mod size. Bit-reversed post-increment by one walks an N-point transform in reversed order. Software loads the base and the log2 of the region size through a configuration strobe. Memory and the multiply-accumulate datapath sit outside this block.

Top module: `dsp_agu`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `addr_vld` is 0 and `addr_out` is 0. Reset leaves the base at 0, the offset at 0 and the size exponent k at 1.
- R2: A request with `mode` = 0 (absolute) returns `imm` and leaves the offset unchanged.
- R3: A request with `mode` = 1 (indirect) returns base + index(offset). A request with `mode` = 2 (displacement) returns base + index(offset) + `step`. Neither changes the offset.
- R4: A request with `mode` = 3 (post-increment) returns the address of the current offset. The offset then becomes offset + `step`.
- R5: A request with `mode` = 4 (pre-decrement) first forms offset - `step`, returns the address of that new offset and stores it.
- R6: With `wrap` = 1 (circular), index(offset) = offset AND (2^k - 1). After a post-increment or pre-decrement, the stored offset is also masked this way, so every address lies in [base, base + 2^k - 1].
- R7: With `wrap` = 2 (bit-reversed), index(offset) is the low k bits of the offset in reversed bit order. The stored offset is masked as in R6. With k = 3, post-increment by one yields base + 0, 4, 2, 6, 1, 5, 3, 7 and then base + 0 again. `wrap` = 0 or 3 is linear: index(offset) = offset, with no masking.
- R8: A cycle with `cfg_we` high loads `cfg_base` and the size exponent and clears the offset to 0. The new values take effect from the next cycle. A request in that same cycle is ignored and yields no address.
- R9: The loaded exponent is clamped to the range 1..MAXLOG: a value of 0 becomes 1, and a value above MAXLOG becomes MAXLOG.
- R10: Requests with `mode` = 5, 6 or 7 yield no address and leave the offset unchanged.
- R11: Every accepted request sets `addr_vld` with its address exactly one cycle later. Requests on consecutive cycles give addresses on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Load base and size exponent, clear offset |
| cfg_base | input | AW | Base address to load |
| cfg_log2 | input | LW | Region size exponent k to load (clamped) |
| req | input | 1 | Address request this cycle |
| mode | input | 3 | 0 absolute, 1 indirect, 2 displacement, 3 post-increment, 4 pre-decrement |
| wrap | input | 2 | 0 linear, 1 circular, 2 bit-reversed, 3 linear |
| step | input | AW | Increment, decrement or displacement amount |
| imm | input | AW | Absolute address for mode 0 |
| addr_out | output | AW | Generated address |
| addr_vld | output | 1 | `addr_out` holds a new address |

## Verification
The hardest state to reach is an offset that has already been masked into the region by one stepping style and is then read through another. Examples are a circular pre-decrement past zero followed by a bit-reversed read, or a load that arrives together with a request. The stimulus gets there by chaining long runs of post-increments and pre-decrements across wrap boundaries. It switches the index style on the same offset between runs and places configuration strobes next to requests. Indirect reads then expose the stored offset at the ports.

// File: rtl/dsp_agu.sv
module dsp_agu #(
  parameter int AW     = 16,
  parameter int MAXLOG = 10,
  parameter int LW     = $clog2(MAXLOG + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_base,
  input  logic [LW-1:0] cfg_log2,
  input  logic          req,
  input  logic [2:0]    mode,
  input  logic [1:0]    wrap,
  input  logic [AW-1:0] step,
  input  logic [AW-1:0] imm,
  output logic [AW-1:0] addr_out,
  output logic          addr_vld
);

  localparam logic [AW-1:0] ONE    = {{(AW-1){1'b0}}, 1'b1};
  localparam logic [LW-1:0] LG_MIN = LW'(1);
  localparam logic [LW-1:0] LG_MAX = LW'(MAXLOG);

  logic [AW-1:0] base_q, off_q;
  logic [LW-1:0] lg_q;

  logic [AW-1:0] mask;
  logic          wrapped;
  logic [AW-1:0] inc_off, dec_off;
  logic [AW-1:0] cur_a, dec_a;
  logic [LW-1:0] lg_in;
  logic          take;

  assign mask    = (ONE << lg_q) - ONE;
  assign wrapped = (wrap == 2'd1) || (wrap == 2'd2);
  assign inc_off = wrapped ? ((off_q + step) & mask) : (off_q + step);
  assign dec_off = wrapped ? ((off_q - step) & mask) : (off_q - step);
  assign take    = req && !cfg_we;
  assign lg_in   = (cfg_log2 == '0) ? LG_MIN :
                   (cfg_log2 > LG_MAX) ? LG_MAX : cfg_log2;

  function automatic logic [AW-1:0] brev(input logic [AW-1:0] x, input logic [LW-1:0] n);
    logic [AW-1:0] r;
    r = '0;
    for (int i = 0; i < MAXLOG; i++)
      if (i < int'(n)) r[int'(n) - 1 - i] = x[i];
    return r;
  endfunction

  function automatic logic [AW-1:0] index_of(input logic [AW-1:0] o);
    case (wrap)
      2'd1:    return o & mask;
      2'd2:    return brev(o & mask, lg_q);
      default: return o;
    endcase
  endfunction

  assign cur_a = base_q + index_of(off_q);
  assign dec_a = base_q + index_of(dec_off);

  logic [AW-1:0] a_d, off_d;
  logic          v_d;

  always_comb begin
    a_d   = addr_out;
    v_d   = 1'b0;
    off_d = off_q;
    if (take) begin
      case (mode)
        3'd0: begin a_d = imm;          v_d = 1'b1; end
        3'd1: begin a_d = cur_a;        v_d = 1'b1; end
        3'd2: begin a_d = cur_a + step; v_d = 1'b1; end
        3'd3: begin a_d = cur_a;        v_d = 1'b1; off_d = inc_off; end
        3'd4: begin a_d = dec_a;        v_d = 1'b1; off_d = dec_off; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q   <= '0;
      lg_q     <= LG_MIN;
      off_q    <= '0;
      addr_out <= '0;
      addr_vld <= 1'b0;
    end else begin
      addr_vld <= v_d;
      addr_out <= a_d;
      if (cfg_we) begin
        base_q <= cfg_base;
        lg_q   <= lg_in;
        off_q  <= '0;
      end else begin
        off_q  <= off_d;
      end
    end
  end

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    !rst_n |=> (!addr_vld && addr_out == '0));

  a_r2_absolute_passes_imm: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req && !cfg_we && mode == 3'd0) |-> addr_out == $past(imm));

  a_r6_circular_in_region: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req && !cfg_we && wrap == 2'd1 && (mode == 3'd1 || mode == 3'd3 || mode == 3'd4))
    |-> (addr_out - $past(base_q)) <= $past(mask));

  a_r8_load_clears_offset: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_we) |-> off_q == '0);

  a_r9_exponent_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    lg_q >= LG_MIN && lg_q <= LG_MAX);

  a_r10_reserved_silent: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req && !cfg_we && mode > 3'd4) |-> (!addr_vld && $stable(off_q)));

  a_r11_one_cycle_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req && !cfg_we && mode <= 3'd4) |-> addr_vld);

endmodule

// File: tb/tb_dsp_agu.sv
module tb_dsp_agu;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int MAXLOG = 10;
  localparam int LW = $clog2(MAXLOG + 1);

  logic          clk = 0;
  logic          rst_n = 0;
  logic          cfg_we = 0;
  logic [AW-1:0] cfg_base = '0;
  logic [LW-1:0] cfg_log2 = '0;
  logic          req = 0;
  logic [2:0]    mode = '0;
  logic [1:0]    wrap = '0;
  logic [AW-1:0] step = '0;
  logic [AW-1:0] imm = '0;
  logic [AW-1:0] addr_out;
  logic          addr_vld;

  dsp_agu #(.AW(AW), .MAXLOG(MAXLOG)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_base(cfg_base),
    .cfg_log2(cfg_log2), .req(req), .mode(mode), .wrap(wrap), .step(step),
    .imm(imm), .addr_out(addr_out), .addr_vld(addr_vld));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [AW-1:0] exp_q[$];
  string         tag_q[$];

  int            m_lg = 1;
  logic [AW-1:0] m_base = '0;
  logic [AW-1:0] m_off = '0;

  function automatic logic [AW-1:0] m_mask();
    return AW'((1 << m_lg) - 1);
  endfunction

  function automatic logic [AW-1:0] m_rev(input logic [AW-1:0] x);
    logic [AW-1:0] r = '0;
    for (int j = 0; j < m_lg; j++) r = (r << 1) | AW'(x[j]);
    return r;
  endfunction

  function automatic logic [AW-1:0] m_idx(input logic [AW-1:0] o, input logic [1:0] w);
    if (w == 2'd1) return o & m_mask();
    if (w == 2'd2) return m_rev(o & m_mask());
    return o;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] m, input logic [1:0] w, input logic [AW-1:0] st,
                       input logic [AW-1:0] im, input string tag);
    logic [AW-1:0] e;
    logic          wr;
    @(negedge clk);
    cfg_we = 0; req = 1; mode = m; wrap = w; step = st; imm = im;
    wr = (w == 2'd1) || (w == 2'd2);
    case (m)
      3'd0: e = im;
      3'd1: e = m_base + m_idx(m_off, w);
      3'd2: e = m_base + m_idx(m_off, w) + st;
      3'd3: begin
        e = m_base + m_idx(m_off, w);
        m_off = wr ? ((m_off + st) & m_mask()) : (m_off + st);
      end
      3'd4: begin
        m_off = wr ? ((m_off - st) & m_mask()) : (m_off - st);
        e = m_base + m_idx(m_off, w);
      end
      default: e = 'x;
    endcase
    if (m <= 3'd4) begin
      exp_q.push_back(e);
      tag_q.push_back(tag);
    end
  endtask

  task automatic load(input logic [AW-1:0] b, input int lg, input bit with_req);
    @(negedge clk);
    cfg_we = 1; cfg_base = b; cfg_log2 = LW'(lg);
    req = with_req; mode = 3'd1; wrap = 2'd0;
    m_base = b;
    m_lg = (lg == 0) ? 1 : (lg > MAXLOG ? MAXLOG : lg);
    m_off = '0;
  endtask

  task automatic idle();
    @(negedge clk);
    cfg_we = 0; req = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && !done && addr_vld) begin
      if (exp_q.size() == 0) begin
        check(0, "R10/R8 unexpected address", addr_out, '0);
      end else begin
        logic [AW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(addr_out == e, t, addr_out, e);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(addr_vld == 0 && addr_out == '0, "R1 reset outputs", {addr_out[AW-2:0], addr_vld}, '0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(addr_vld == 0, "R1 first cycle after reset", {15'b0, addr_vld}, '0);

    issue(3'd1, 2'd0, '0, '0, "R1 reset base/offset zero");
    issue(3'd0, 2'd0, '0, 16'hBEEF, "R2 absolute");
    issue(3'd0, 2'd1, '0, 16'h1234, "R2 absolute circular select");
    issue(3'd1, 2'd0, '0, '0, "R2 offset untouched");

    load(16'h0100, 3, 0);
    for (int i = 0; i < 9; i++) issue(3'd3, 2'd2, 16'd1, '0, "R7 bit-reversed 8-point");
    issue(3'd1, 2'd2, '0, '0, "R7 bit-reversed read");

    load(16'h0200, 2, 0);
    for (int i = 0; i < 6; i++) issue(3'd3, 2'd1, 16'd1, '0, "R6 circular post-increment");
    load(16'h0200, 2, 0);
    for (int i = 0; i < 5; i++) issue(3'd4, 2'd1, 16'd1, '0, "R5/R6 circular pre-decrement");
    issue(3'd3, 2'd1, 16'd3, '0, "R6 circular step 3");
    issue(3'd1, 2'd2, '0, '0, "R7 reversed view of circular offset");

    load(16'h1000, 4, 0);
    issue(3'd3, 2'd0, 16'd3, '0, "R4 linear post-increment");
    issue(3'd3, 2'd0, 16'd3, '0, "R4 linear post-increment");
    issue(3'd1, 2'd0, '0, '0, "R3 indirect after post-increment");
    issue(3'd4, 2'd0, 16'd2, '0, "R5 linear pre-decrement");
    issue(3'd2, 2'd0, 16'd16, '0, "R3 displacement");
    issue(3'd2, 2'd3, 16'h0FF0, '0, "R7 wrap code 3 linear");
    issue(3'd4, 2'd0, 16'd20, '0, "R5 linear pre-decrement below zero");

    issue(3'd5, 2'd0, 16'd7, '0, "R10 reserved 5");
    issue(3'd6, 2'd1, 16'd7, '0, "R10 reserved 6");
    issue(3'd7, 2'd2, 16'd7, '0, "R10 reserved 7");
    idle();
    issue(3'd1, 2'd0, '0, '0, "R10 offset unchanged");

    load(16'h0300, 5, 1);
    issue(3'd1, 2'd0, '0, '0, "R8 load clears offset");
    issue(3'd3, 2'd1, 16'd40, '0, "R8 new size in effect");
    issue(3'd1, 2'd1, '0, '0, "R8 new size in effect");

    load(16'h0400, 0, 0);
    issue(3'd3, 2'd1, 16'd3, '0, "R9 exponent 0 clamps to 1");
    issue(3'd1, 2'd1, '0, '0, "R9 exponent 0 clamps to 1");
    load(16'h0000, 15, 0);
    issue(3'd3, 2'd2, 16'd1, '0, "R9 exponent clamps to MAXLOG");
    issue(3'd1, 2'd2, '0, '0, "R9 exponent clamps to MAXLOG");
    issue(3'd3, 2'd1, 16'd1023, '0, "R9 circular at MAXLOG");
    issue(3'd1, 2'd1, '0, '0, "R9 circular at MAXLOG wrap");

    idle();
    idle();
    check(exp_q.size() == 0, "R11 every request answered", AW'(exp_q.size()), '0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule